// File: doc/BRIEF.md
# Error Signaling Pin Controller

This block gathers error events raised by on-chip diagnostics into three groups (low, medium and high severity) and drives one active-low pin toward an external safety monitor. Each group keeps a sticky flag per event line. Software clears a flag by writing one to its bit. A high-severity event, or a diagnostic force request written by software, pulls the pin low for a programmable minimum number of clock cycles. The external monitor can use that duration to tell a real fault from a self-test.

Two resets are provided. The power-on reset clears everything. The system reset only returns the preload register and the read port to their defaults. The sticky flags, the running low-time counter and the pin keep their state across a system reset, so software can read the cause after recovery. A small synchronous register port gives access to the preload, the three flag registers, the live pin level and the force request.

Top module: `err_pin_ctrl`

## Requirements
- R1: After power-on reset, err_n is 1, all three flag registers read 0 and the preload register reads PRE_RST.
- R2: Any bit of evt_high sampled at a clock edge drives err_n to 0 after that edge. err_n then stays 0 for exactly P cycles, where P is the preload (a preload of 0 behaves as 1), and returns to 1 after that.
- R3: A high-severity event that arrives while err_n is low reloads the counter. err_n then stays low for P cycles counted from the last event.
- R4: Writing a value with bit 0 set to address 5 (force) drives err_n exactly as a high-severity event does, and sets no flag.
- R5: Events on evt_low and evt_mid leave err_n at 1.
- R6: Bit i of evt_low, evt_mid and evt_high sets bit i of the flag register at address 1, 2 and 3 respectively, and that bit stays set.
- R7: Writing to a flag address clears each flag whose wdata bit is 1. Flags whose wdata bit is 0 are not changed.
- R8: If a new event and a write-one-to-clear hit the same flag bit in the same cycle, the flag stays set.
- R9: sys_rst does not pull err_n low, clears no flag and does not stop a running low time. It resets the preload at address 0 to PRE_RST.
- R10: A read of address 4 returns in bit 0 the level err_n had at the edge where the read was sampled.
- R11: When rd_en is sampled at an edge, rd_vld is 1 in the next cycle and rdata holds the value of the addressed register. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| evt_low | input | GRP_W | Low-severity event lines |
| evt_mid | input | GRP_W | Medium-severity event lines |
| evt_high | input | GRP_W | High-severity event lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| rd_vld | output | 1 | Read data valid |
| err_n | output | 1 | Active-low error pin, registered |

## Verification
The bench builds the block with GRP_W=4, CNT_W=6 and PRE_RST=5. With these values every flag bit fits in a short hex compare, and the low-time windows are only a handful of cycles long. That makes it possible to check every cycle of each low window, including its exact trailing edge. The cases covered are a reload in the middle of a window, a zero preload, a forced self-test pulse, and a system reset that arrives while the pin is low.

// File: rtl/err_pin_pkg.sv
package err_pin_pkg;
  localparam int NUM_GRP = 3;
  localparam int HI_GRP  = 2;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_PRELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] A_GRP0    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PIN     = 3'd4;
  localparam logic [ADDR_W-1:0] A_FORCE   = 3'd5;
endpackage

// File: rtl/evt_group_flags.sv
module evt_group_flags #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic [GRP_W-1:0] evt,
  input  logic [GRP_W-1:0] clr,
  output logic [GRP_W-1:0] flags
);
  logic [GRP_W-1:0] flags_q;

  // a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (por_rst) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr) | evt;
  end

  assign flags = flags_q;

  // R6
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (por_rst)
    (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));

  // R7
  flag_drop_needs_clr_chk: assert property (@(posedge clk) disable iff (por_rst)
    ((~flags_q & $past(flags_q) & ~$past(clr)) == '0));
endmodule

// File: rtl/err_low_timer.sv
module err_low_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             trig,
  input  logic [CNT_W-1:0] preload,
  output logic             err_n
);
  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             err_n_q;

  always_comb begin
    load_val = (preload == '0) ? CNT_W'(1) : preload;
    if (trig)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    else                   cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      cnt_q   <= '0;
      err_n_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      err_n_q <= (cnt_d == '0);
    end
  end

  assign err_n = err_n_q;

  // R2
  trig_pulls_low_chk: assert property (@(posedge clk) disable iff (por_rst)
    trig |=> !err_n_q);

  // R3
  trig_reloads_chk: assert property (@(posedge clk) disable iff (por_rst)
    trig |=> (cnt_q == (($past(preload) == '0) ? CNT_W'(1) : $past(preload))));

  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (por_rst)
    (!trig && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9
  fall_needs_trig_chk: assert property (@(posedge clk) disable iff (por_rst)
    $fell(err_n_q) |-> $past(trig));
endmodule

// File: rtl/err_reg_port.sv
module err_reg_port
  import err_pin_pkg::*;
#(
  parameter int GRP_W   = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int PRE_RST = 16
) (
  input  logic                     clk,
  input  logic                     por_rst,
  input  logic                     sys_rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_GRP*GRP_W-1:0] flags,
  input  logic                     err_n,
  output logic [CNT_W-1:0]         preload,
  output logic [NUM_GRP*GRP_W-1:0] clr,
  output logic                     diag,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rd_vld
);
  logic [CNT_W-1:0]  pre_q;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              vld_q;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_clr
      assign clr[g*GRP_W +: GRP_W] =
        (wr_en && addr == A_GRP0 + ADDR_W'(g)) ? wdata[GRP_W-1:0] : '0;
    end
  endgenerate

  assign diag = wr_en && (addr == A_FORCE) && wdata[0];

  always_comb begin
    rd_d = '0;
    if (addr == A_PRELOAD)      rd_d[CNT_W-1:0] = pre_q;
    else if (addr == A_PIN)     rd_d[0] = err_n;
    else begin
      for (int k = 0; k < NUM_GRP; k++)
        if (addr == A_GRP0 + ADDR_W'(k))
          rd_d[GRP_W-1:0] = flags[k*GRP_W +: GRP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst || sys_rst) begin
      pre_q <= CNT_W'(PRE_RST);
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_PRELOAD) pre_q <= wdata[CNT_W-1:0];
      vld_q <= rd_en;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign preload = pre_q;
  assign rdata   = rd_q;
  assign rd_vld  = vld_q;

  // R11
  read_valid_next_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    rd_en |=> rd_vld);
endmodule

// File: rtl/err_pin_ctrl.sv
module err_pin_ctrl
  import err_pin_pkg::*;
#(
  parameter int GRP_W   = 8,
  parameter int CNT_W   = 16,
  parameter int PRE_RST = 16,
  localparam int DATA_W = (GRP_W > CNT_W) ? GRP_W : CNT_W
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic [GRP_W-1:0]  evt_low,
  input  logic [GRP_W-1:0]  evt_mid,
  input  logic [GRP_W-1:0]  evt_high,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_vld,
  output logic              err_n
);
  logic [NUM_GRP*GRP_W-1:0] evt_all, flags_all, clr_all;
  logic [CNT_W-1:0]         preload;
  logic                     diag, pin_trig;

  assign evt_all  = {evt_high, evt_mid, evt_low};
  assign pin_trig = (|evt_all[HI_GRP*GRP_W +: GRP_W]) || diag;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      evt_group_flags #(.GRP_W(GRP_W)) u_flags (
        .clk     (clk),
        .por_rst (por_rst),
        .evt     (evt_all[g*GRP_W +: GRP_W]),
        .clr     (clr_all[g*GRP_W +: GRP_W]),
        .flags   (flags_all[g*GRP_W +: GRP_W])
      );
    end
  endgenerate

  err_low_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .por_rst (por_rst),
    .trig    (pin_trig),
    .preload (preload),
    .err_n   (err_n)
  );

  err_reg_port #(
    .GRP_W(GRP_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .PRE_RST(PRE_RST)
  ) u_regs (
    .clk     (clk),
    .por_rst (por_rst),
    .sys_rst (sys_rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .flags   (flags_all),
    .err_n   (err_n),
    .preload (preload),
    .clr     (clr_all),
    .diag    (diag),
    .rdata   (rdata),
    .rd_vld  (rd_vld)
  );

  // R5
  low_groups_quiet_chk: assert property (@(posedge clk) disable iff (por_rst)
    (err_n && !pin_trig) |=> err_n);
endmodule

// File: tb/err_pin_ctrl_test.sv
module err_pin_ctrl_test;
  localparam int GRP_W = 4;
  localparam int CNT_W = 6;
  localparam int PRE   = 5;
  localparam int DW    = 6;

  logic clk = 1'b0;
  logic por_rst = 1'b1, sys_rst = 1'b0;
  logic [GRP_W-1:0] evt_low = '0, evt_mid = '0, evt_high = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_vld, err_n;

  int n_run = 0, n_fail = 0, n_push = 0, n_pop = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  err_pin_ctrl #(.GRP_W(GRP_W), .CNT_W(CNT_W), .PRE_RST(PRE)) uut (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
    .evt_low(evt_low), .evt_mid(evt_mid), .evt_high(evt_high),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_vld(rd_vld), .err_n(err_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rd_vld) begin
      if (exp_q.size() == 0) chk("R11 unexpected rd_vld", 1, 0);
      else begin
        n_pop++;
        chk(tag_q.pop_front(), int'(rdata), int'(exp_q.pop_front()));
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(DW'(exp)); tag_q.push_back(tag); n_push++;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; addr = a; wdata = DW'(d);
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse_hi(input logic [GRP_W-1:0] b);
    evt_high = b;
    @(negedge clk); evt_high = '0;
  endtask

  // pin low for n falling edges starting now, then high
  task automatic low_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(tag, int'(err_n), 0);
      @(negedge clk);
    end
    chk(tag, int'(err_n), 1);
  endtask

  initial begin
    #(8 * 100000);
    chk("watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    @(negedge clk);
    chk("R1 pin idle", int'(err_n), 1);
    rd(3'd0, PRE, "R1 preload default");
    rd(3'd1, 0, "R1 grp0 clear");
    rd(3'd3, 0, "R1 grp2 clear");
    @(negedge clk);

    pulse_hi(4'b0010);
    low_run(PRE, "R2 low window");
    rd(3'd3, 2, "R6 grp2 flag");

    wr(3'd0, 3);
    pulse_hi(4'b0001);
    chk("R3 low before reload", int'(err_n), 0);
    @(negedge clk);
    pulse_hi(4'b0001);
    low_run(3, "R3 reload window");

    pulse_hi(4'b0100);
    rd(3'd4, 0, "R10 pin low readback");
    repeat (5) @(negedge clk);
    rd(3'd4, 1, "R10 pin high readback");

    wr(3'd0, 0);
    pulse_hi(4'b0001);
    low_run(1, "R2 zero preload");
    wr(3'd0, 3);

    wr(3'd5, 1);
    low_run(3, "R4 force window");
    rd(3'd3, 7, "R4 force sets no flag");

    evt_low = 4'b0101; evt_mid = 4'b1000;
    @(negedge clk); evt_low = '0; evt_mid = '0;
    for (int i = 0; i < 6; i++) begin
      chk("R5 pin stays high", int'(err_n), 1);
      @(negedge clk);
    end
    rd(3'd1, 5, "R6 grp0 flags");
    rd(3'd2, 8, "R6 grp1 flags");

    wr(3'd1, 1);
    rd(3'd1, 4, "R7 w1c clears one");
    wr(3'd2, 0);
    rd(3'd2, 8, "R7 zero write keeps");

    evt_low = 4'b0100;
    wr(3'd1, 4);
    evt_low = '0;
    rd(3'd1, 4, "R8 event beats clear");
    wr(3'd1, 4);
    rd(3'd1, 0, "R8 later clear works");

    wr(3'd0, 7);
    sys_rst = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 sysrst pin high", int'(err_n), 1);
    end
    sys_rst = 1'b0;
    @(negedge clk);
    rd(3'd0, PRE, "R9 preload back to default");
    rd(3'd2, 8, "R9 grp1 kept");
    rd(3'd3, 7, "R9 grp2 kept");

    pulse_hi(4'b1000);
    sys_rst = 1'b1;
    chk("R9 low under sysrst", int'(err_n), 0);
    @(negedge clk);
    chk("R9 low under sysrst", int'(err_n), 0);
    @(negedge clk);
    sys_rst = 1'b0;
    low_run(PRE - 2, "R9 window survives sysrst");

    rd(3'd6, 0, "R11 unmapped 6");
    rd(3'd7, 0, "R11 unmapped 7");
    repeat (3) @(negedge clk);
    chk("R11 all reads answered", n_pop, n_push);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule